// File: doc/BRIEF.md
# Supervisor Timer Compare Interrupt Unit

This unit produces two level-type timer interrupt requests from one free-running 64-bit time count. The supervisor request compares the raw time against its own compare register. The virtual-supervisor request first adds a 64-bit guest offset to the time, with the sum wrapping modulo 2^64, and then compares it against a second compare register. Both comparisons treat the values as unsigned.

Software writes the two compare values and the offset through a single write port. A 2-bit select picks the target register. A combinational read port returns the stored values.

Each request is registered. It follows its compare condition one clock edge later, so software clears a request by writing a compare value that lies in the future. Privilege checks, interrupt enables, delegation and the source of the time count all sit outside this unit.

Top module: `stcmp_top`

## Requirements
- R1: `s_pend_o` equals, one clock edge later, the unsigned test `time_i >= S compare`.
- R2: `vs_pend_o` equals, one clock edge later, the unsigned test `(time_i + offset) mod 2^64 >= VS compare`.
- R3: Each request is a level. It stays high while its condition holds and falls once the compare value exceeds the effective time.
- R4: A compare write takes part in the comparison at the same clock edge it is stored on. A value at or below the effective time sets the request on that edge. A larger value clears it on that edge.
- R5: The VS comparison at the edge that stores a new offset still uses the old offset. The new offset counts from the following edge.
- R6: With a compare value of all ones, the request is high only after an edge at which time (or effective time) was all ones. It drops once that value wraps to zero.
- R7: While reset is active, both requests are low. After reset, all three registers read as zero.
- R8: A write to one compare register never changes the other request or the other register.
- R9: The write select encodes 0 = S compare, 1 = VS compare, 2 = offset. A write with select 3 changes no register and no request.
- R10: `rd_data_o` combinationally returns the register chosen by `rd_sel_i`, using the same encoding. Select 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| time_i | input | 64 | Free-running time count |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 S compare, 1 VS compare, 2 offset |
| wr_data_i | input | 64 | Write data |
| rd_sel_i | input | 2 | Read target, same encoding, 3 reads zero |
| rd_data_o | output | 64 | Read data |
| s_pend_o | output | 1 | Supervisor timer request |
| vs_pend_o | output | 1 | Virtual-supervisor timer request |

## Verification
The assertions assume that `time_i`, the write strobe, the select and the data are stable around each rising edge. They also assume the checks begin only one full cycle after the internal reset is released, so every past value they refer to was captured outside reset. The bench drives all inputs on the falling edge. It keeps the write port idle during the reset release and then steps the time count by hand, including jumps and wrap-around values, rather than by increment. That keeps each compare relation explicit for every vector.

// File: rtl/stcmp_pkg.sv
package stcmp_pkg;
  localparam int unsigned TW   = 64;
  localparam int unsigned NREG = 3;
  localparam int unsigned SELW = 2;

  typedef enum logic [SELW-1:0] {
    SEL_SCMP  = 2'd0,
    SEL_VSCMP = 2'd1,
    SEL_OFS   = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/stcmp_regs.sv
module stcmp_regs
  import stcmp_pkg::*;
#(
  parameter int unsigned W = TW,
  parameter int unsigned N = NREG
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en_i,
  input  logic [SELW-1:0]       wr_sel_i,
  input  logic [W-1:0]          wr_data_i,
  output logic [N-1:0][W-1:0]   regs_o
);
  for (genvar g = 0; g < N; g++) begin : g_reg
    logic         en;
    logic [W-1:0] d;
    logic [W-1:0] q;

    always_comb begin
      en = wr_en_i && (wr_sel_i == SELW'(g));
      d  = en ? wr_data_i : q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end

    assign regs_o[g] = q;
  end
endmodule

// File: rtl/stcmp_cmp.sv
module stcmp_cmp
  import stcmp_pkg::*;
#(
  parameter int unsigned W       = TW,
  parameter bit          USE_OFS = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] time_i,
  input  logic [W-1:0] ofs_i,
  input  logic [W-1:0] cmp_q_i,
  input  logic         wr_hit_i,
  input  logic [W-1:0] wr_data_i,
  output logic         pend_o
);
  logic [W-1:0] eff_time;
  logic [W-1:0] cmp_eff;
  logic         pend_d;
  logic         pend_q;

  if (USE_OFS) begin : g_ofs
    assign eff_time = time_i + ofs_i;
  end else begin : g_raw
    logic unused_ofs;
    assign unused_ofs = ^ofs_i;
    assign eff_time   = time_i;
  end

  always_comb begin
    cmp_eff = wr_hit_i ? wr_data_i : cmp_q_i;
    pend_d  = (eff_time >= cmp_eff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/stcmp_top.sv
module stcmp_top
  import stcmp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TW-1:0]   time_i,
  input  logic            wr_en_i,
  input  logic [SELW-1:0] wr_sel_i,
  input  logic [TW-1:0]   wr_data_i,
  input  logic [SELW-1:0] rd_sel_i,
  output logic [TW-1:0]   rd_data_o,
  output logic            s_pend_o,
  output logic            vs_pend_o
);
  logic [1:0]               rst_sync_q;
  logic                     rst_sync_n;
  logic [NREG-1:0][TW-1:0]  regs;
  logic [TW-1:0]            scmp_q;
  logic [TW-1:0]            vscmp_q;
  logic [TW-1:0]            ofs_q;
  logic                     s_hit;
  logic                     vs_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  stcmp_regs #(.W(TW), .N(NREG)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .regs_o    (regs)
  );

  assign scmp_q  = regs[SEL_SCMP];
  assign vscmp_q = regs[SEL_VSCMP];
  assign ofs_q   = regs[SEL_OFS];
  assign s_hit   = wr_en_i && (wr_sel_i == SEL_SCMP);
  assign vs_hit  = wr_en_i && (wr_sel_i == SEL_VSCMP);

  stcmp_cmp #(.W(TW), .USE_OFS(1'b0)) u_s_cmp (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .time_i    (time_i),
    .ofs_i     ('0),
    .cmp_q_i   (scmp_q),
    .wr_hit_i  (s_hit),
    .wr_data_i (wr_data_i),
    .pend_o    (s_pend_o)
  );

  stcmp_cmp #(.W(TW), .USE_OFS(1'b1)) u_vs_cmp (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .time_i    (time_i),
    .ofs_i     (ofs_q),
    .cmp_q_i   (vscmp_q),
    .wr_hit_i  (vs_hit),
    .wr_data_i (wr_data_i),
    .pend_o    (vs_pend_o)
  );

  always_comb begin
    unique case (rd_sel_i)
      SEL_SCMP:  rd_data_o = scmp_q;
      SEL_VSCMP: rd_data_o = vscmp_q;
      SEL_OFS:   rd_data_o = ofs_q;
      default:   rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/stcmp_chk.sv
module stcmp_chk
  import stcmp_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [TW-1:0]   time_i,
  input logic            wr_en_i,
  input logic [SELW-1:0] wr_sel_i,
  input logic [TW-1:0]   wr_data_i,
  input logic [TW-1:0]   scmp_q,
  input logic [TW-1:0]   vscmp_q,
  input logic [TW-1:0]   ofs_q,
  input logic            s_pend_o,
  input logic            vs_pend_o
);
  logic armed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  // R1
  s_match_chk: assert property (@(posedge clk) disable iff (!armed_q)
    !$past(wr_en_i && wr_sel_i == SEL_SCMP)
      |-> s_pend_o == ($past(time_i) >= $past(scmp_q)));

  // R2
  vs_match_chk: assert property (@(posedge clk) disable iff (!armed_q)
    !$past(wr_en_i && wr_sel_i == SEL_VSCMP)
      |-> vs_pend_o == (($past(time_i) + $past(ofs_q)) >= $past(vscmp_q)));

  // R4
  s_write_prio_chk: assert property (@(posedge clk) disable iff (!armed_q)
    $past(wr_en_i && wr_sel_i == SEL_SCMP)
      |-> s_pend_o == ($past(time_i) >= $past(wr_data_i)));

  // R6
  s_allones_wrap_chk: assert property (@(posedge clk) disable iff (!armed_q)
    ($past(scmp_q) == '1 && $past(time_i) == '0 && !$past(wr_en_i))
      |-> !s_pend_o);

  // R8
  s_reg_isolated_chk: assert property (@(posedge clk) disable iff (!armed_q)
    $past(wr_en_i && wr_sel_i != SEL_SCMP) |-> scmp_q == $past(scmp_q));

  // R9
  sel_none_chk: assert property (@(posedge clk) disable iff (!armed_q)
    $past(wr_en_i && wr_sel_i == SEL_NONE)
      |-> (vscmp_q == $past(vscmp_q)) && (ofs_q == $past(ofs_q)));
endmodule

bind stcmp_top stcmp_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .time_i    (time_i),
  .wr_en_i   (wr_en_i),
  .wr_sel_i  (wr_sel_i),
  .wr_data_i (wr_data_i),
  .scmp_q    (scmp_q),
  .vscmp_q   (vscmp_q),
  .ofs_q     (ofs_q),
  .s_pend_o  (s_pend_o),
  .vs_pend_o (vs_pend_o)
);

// File: tb/stcmp_top_tb.sv
module stcmp_top_tb;
  localparam logic [63:0] ONES = '1;
  localparam int NV = 19;

  // {we, sel[1:0], data[63:0], time[63:0], exp_s, exp_vs}
  localparam logic [132:0] VEC [NV] = '{
    {1'b0, 2'd0, 64'd0,    64'd5,    1'b1, 1'b1},  // R1 R2 reset compares are zero
    {1'b1, 2'd0, 64'd100,  64'd50,   1'b0, 1'b1},  // R4 future S clears
    {1'b0, 2'd0, 64'd0,    64'd99,   1'b0, 1'b1},  // R1
    {1'b0, 2'd0, 64'd0,    64'd100,  1'b1, 1'b1},  // R1 equal
    {1'b1, 2'd1, 64'd1000, 64'd100,  1'b1, 1'b0},  // R8 R4
    {1'b1, 2'd2, 64'd900,  64'd100,  1'b1, 1'b0},  // R5 old offset
    {1'b0, 2'd0, 64'd0,    64'd100,  1'b1, 1'b1},  // R5 new offset
    {1'b1, 2'd0, 64'd40,   64'd101,  1'b1, 1'b1},  // R4 past write
    {1'b1, 2'd0, 64'd200,  64'd101,  1'b0, 1'b1},  // R3 R4
    {1'b1, 2'd1, 64'd2000, 64'd101,  1'b0, 1'b0},  // R3
    {1'b0, 2'd0, 64'd0,    64'd1099, 1'b1, 1'b0},  // R2
    {1'b0, 2'd0, 64'd0,    64'd1100, 1'b1, 1'b1},  // R2 equal
    {1'b1, 2'd2, ONES,     64'd1100, 1'b1, 1'b1},  // R5
    {1'b0, 2'd0, 64'd0,    64'd1100, 1'b1, 1'b0},  // R2 wrapping offset
    {1'b1, 2'd1, 64'd5,    64'd3,    1'b0, 1'b0},  // R2
    {1'b0, 2'd0, 64'd0,    64'd6,    1'b0, 1'b1},  // R3
    {1'b1, 2'd2, 64'd0,    64'd0,    1'b0, 1'b1},  // R5 wrap 0-1
    {1'b0, 2'd0, 64'd0,    64'd0,    1'b0, 1'b0},  // R2
    {1'b1, 2'd3, 64'd0,    64'd0,    1'b0, 1'b0}   // R9
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] time_i = '0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_sel_i = '0;
  logic [63:0] wr_data_i = '0;
  logic [1:0]  rd_sel_i = '0;
  logic [63:0] rd_data_o;
  logic        s_pend_o;
  logic        vs_pend_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  stcmp_top u_dut (
    .clk(clk), .rst_n(rst_n), .time_i(time_i), .wr_en_i(wr_en_i),
    .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .rd_sel_i(rd_sel_i),
    .rd_data_o(rd_data_o), .s_pend_o(s_pend_o), .vs_pend_o(vs_pend_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [1:0] sel,
                      input logic [63:0] data, input logic [63:0] t);
    wr_en_i = we; wr_sel_i = sel; wr_data_i = data; time_i = t;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input string req, input logic [1:0] sel, input logic [63:0] exp);
    rd_sel_i = sel;
    #0.5;
    chk(req, rd_data_o, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R7 s low in reset", 64'(s_pend_o), 64'd0);
    chk("R7 vs low in reset", 64'(vs_pend_o), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd("R7 S reads zero", 2'd0, 64'd0);
    rd("R7 VS reads zero", 2'd1, 64'd0);
    rd("R7 offset reads zero", 2'd2, 64'd0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][132], VEC[i][131:130], VEC[i][129:66], VEC[i][65:2]);
      chk($sformatf("R1 R4 vec%0d s", i), 64'(s_pend_o), 64'(VEC[i][1]));
      chk($sformatf("R2 R5 vec%0d vs", i), 64'(vs_pend_o), 64'(VEC[i][0]));
    end

    rd("R9 R10 S kept", 2'd0, 64'd200);
    rd("R10 VS read", 2'd1, 64'd5);
    rd("R10 offset read", 2'd2, 64'd0);
    rd("R10 sel 3 reads zero", 2'd3, 64'd0);

    step(1'b1, 2'd0, ONES, ONES - 64'd1);
    chk("R6 below all ones", 64'(s_pend_o), 64'd0);
    step(1'b0, 2'd0, 64'd0, ONES);
    chk("R6 at all ones", 64'(s_pend_o), 64'd1);
    step(1'b0, 2'd0, 64'd0, 64'd0);
    chk("R6 wrapped to zero", 64'(s_pend_o), 64'd0);
    step(1'b0, 2'd0, 64'd0, 64'd6);
    chk("R8 vs unaffected", 64'(vs_pend_o), 64'd1);
    step(1'b1, 2'd1, ONES, ONES);
    chk("R6 vs at all ones", 64'(vs_pend_o), 64'd1);
    step(1'b0, 2'd0, 64'd0, 64'd0);
    chk("R6 vs wrapped", 64'(vs_pend_o), 64'd0);
    chk("R8 s stays low", 64'(s_pend_o), 64'd0);

    rst_n = 1'b0;
    #0.5;
    chk("R7 s low on reset", 64'(s_pend_o), 64'd0);
    chk("R7 vs low on reset", 64'(vs_pend_o), 64'd0);
    rd("R7 S cleared", 2'd0, 64'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule